// File: doc/BRIEF.md
# Fast-RAM Bus Glue with Clock Stretching

This block sits between an 8-bit microprocessor bus and three kinds of target: fast static RAM in two banks, a small boot ROM and a window of slow peripherals. It takes the free-running system clock, the address and the read/write line. It returns the CPU's phase-2 clock, active-low selects for every target, and active-low RAM output and write strobes. RAM cycles run at the full clock rate. A ROM or peripheral cycle holds the phase-2 clock high, so the high phase lasts until the slow side reports ready.

The lower half of the address space goes to bank 0 on the top address bit alone, which keeps that path as short as it can be. Bank 1 covers $8000 up to $FDFF. The peripheral window is $FF00-$FFBF. The ROM takes what is left at the top: $FE00-$FEFF and $FFC0-$FFFF. The RAM write strobe is gated by the raw clock and not by the stretched phase-2 clock. The write therefore closes at the falling clock edge, before the CPU moves the address in the next low phase.

Top module: `fast_ram_glue`

## Requirements
- R1: Any address with bit 15 clear drives `ram0_cs_n` low, and every other select stays high.
- R2: Addresses $8000 to $FDFF drive `ram1_cs_n` low, and every other select stays high.
- R3: Addresses $FE00 to $FEFF and $FFC0 to $FFFF drive `rom_cs_n` low, and every other select stays high.
- R4: Addresses $FF00 to $FFBF drive `io_cs_n` low, and every other select stays high.
- R5: Exactly one of the four selects is low at any time. The selects depend only on the address.
- R6: A RAM cycle is never stretched. `io_wait` stays 0, and `phi2` equals `clk_src` in both phases.
- R7: A ROM or peripheral address present at a rising edge of `clk_src` raises `io_wait` (1 = stretch active) from that edge on. While `io_wait` is 1, `phi2` is held high through the low phases of `clk_src`.
- R8: `io_ready` (1 = slow side done) is sampled only at the rising edges after the one that raised `io_wait`, so a ready level that is already high does not shorten the cycle. At the first such edge that sees ready high, `io_wait` drops. `phi2` then falls with the next falling edge of `clk_src`, so the shortest stretched cycle lasts two clock periods.
- R9: `ram_we_n` is low only while `clk_src` is high, `rw` is 0 (write) and a RAM bank is addressed. It rises with the falling edge of `clk_src`, while the address is still unchanged.
- R10: `ram_oe_n` is low only when `rw` is 1 (read) and a RAM bank is addressed. During a ROM or peripheral cycle, both `ram_oe_n` and `ram_we_n` stay high.
- R11: While `rst_n` is 0, the stretch state is cleared at once: `io_wait` is 0 and `phi2` follows `clk_src`, even when a slow address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address bus |
| rw | input | 1 | 1 = read, 0 = write |
| io_ready | input | 1 | Slow side finished, 1 = ready |
| phi2 | output | 1 | Stretched phase-2 clock to the CPU |
| ram0_cs_n | output | 1 | Select for RAM bank 0, active low |
| ram1_cs_n | output | 1 | Select for RAM bank 1, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| rom_cs_n | output | 1 | ROM select, active low |
| io_cs_n | output | 1 | Peripheral window select, active low |
| io_wait | output | 1 | Stretch in progress |

## Verification
The properties assume the bus behaves like the CPU it serves. The address and `rw` change only in a low phase of `clk_src` while `phi2` is low, and a slow address never stays on the bus for a second cycle once its stretch has been released. The bench follows this in every case. It drives new bus values half a nanosecond after a falling edge, and it puts a bank-0 read back on the bus in the low phase that closes each stretched cycle. `io_ready` is changed only in low phases. This lets the properties that sample at the rising edge see a settled low phase.

// File: rtl/glue_pkg.sv
`timescale 1ns/1ps
package glue_pkg;

    // one-hot target select, active high inside the block
    typedef struct packed {
        logic ram0;
        logic ram1;
        logic rom;
        logic io;
    } sel_t;

    // registered state of the stretch controller
    typedef struct packed {
        logic hold;
    } stretch_t;

endpackage

// File: rtl/glue_decode.sv
`timescale 1ns/1ps
module glue_decode #(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] RAM1_LIMIT = 16'hFDFF,
    parameter logic [ADDR_W-1:0] IO_BASE    = 16'hFF00,
    parameter logic [ADDR_W-1:0] IO_LIMIT   = 16'hFFBF
) (
    input  logic [ADDR_W-1:0] addr,
    output glue_pkg::sel_t    sel
);
    localparam int unsigned MSB = ADDR_W - 1;

    logic upper;
    logic in_io;

    always_comb begin
        upper    = addr[MSB];
        in_io    = (addr >= IO_BASE) && (addr <= IO_LIMIT);
        // bank 0 looks at the top bit only: shortest path
        sel.ram0 = ~upper;
        sel.ram1 = upper && (addr <= RAM1_LIMIT);
        sel.io   = in_io;
        sel.rom  = upper && (addr > RAM1_LIMIT) && !in_io;
    end
endmodule

// File: rtl/glue_stretch.sv
`timescale 1ns/1ps
module glue_stretch (
    input  logic clk_src,
    input  logic rst_n,
    input  logic slow_sel,
    input  logic io_ready,
    output logic hold
);
    glue_pkg::stretch_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.hold) begin
            // ready is looked at only once the stretch is running
            s_d.hold = !io_ready;
        end else begin
            s_d.hold = slow_sel;
        end
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hold = s_q.hold;
endmodule

// File: rtl/glue_strobe.sv
`timescale 1ns/1ps
module glue_strobe (
    input  logic           clk_src,
    input  logic           hold,
    input  logic           rw,
    input  glue_pkg::sel_t sel,
    output logic           phi2,
    output logic           ram0_cs_n,
    output logic           ram1_cs_n,
    output logic           ram_oe_n,
    output logic           ram_we_n,
    output logic           rom_cs_n,
    output logic           io_cs_n
);
    logic ram_hit;

    always_comb begin
        ram_hit   = sel.ram0 | sel.ram1;
        // stretch forces the phase-2 clock high
        phi2      = clk_src | hold;
        ram0_cs_n = ~sel.ram0;
        ram1_cs_n = ~sel.ram1;
        rom_cs_n  = ~sel.rom;
        io_cs_n   = ~sel.io;
        ram_oe_n  = ~(ram_hit & rw);
        // raw clock, not phi2: the write closes at the falling edge
        ram_we_n  = ~(ram_hit & ~rw & clk_src);
    end
endmodule

// File: rtl/fast_ram_glue.sv
`timescale 1ns/1ps
module fast_ram_glue #(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] RAM1_LIMIT = 16'hFDFF,
    parameter logic [ADDR_W-1:0] IO_BASE    = 16'hFF00,
    parameter logic [ADDR_W-1:0] IO_LIMIT   = 16'hFFBF
) (
    input  logic              clk_src,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic              io_ready,
    output logic              phi2,
    output logic              ram0_cs_n,
    output logic              ram1_cs_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic              rom_cs_n,
    output logic              io_cs_n,
    output logic              io_wait
);
    glue_pkg::sel_t sel;
    logic           hold;

    glue_decode #(
        .ADDR_W    (ADDR_W),
        .RAM1_LIMIT(RAM1_LIMIT),
        .IO_BASE   (IO_BASE),
        .IO_LIMIT  (IO_LIMIT)
    ) u_decode (
        .addr(addr),
        .sel (sel)
    );

    glue_stretch u_stretch (
        .clk_src (clk_src),
        .rst_n   (rst_n),
        .slow_sel(sel.rom | sel.io),
        .io_ready(io_ready),
        .hold    (hold)
    );

    glue_strobe u_strobe (
        .clk_src  (clk_src),
        .hold     (hold),
        .rw       (rw),
        .sel      (sel),
        .phi2     (phi2),
        .ram0_cs_n(ram0_cs_n),
        .ram1_cs_n(ram1_cs_n),
        .ram_oe_n (ram_oe_n),
        .ram_we_n (ram_we_n),
        .rom_cs_n (rom_cs_n),
        .io_cs_n  (io_cs_n)
    );

    assign io_wait = hold;
endmodule

// File: rtl/fast_ram_glue_chk.sv
`timescale 1ns/1ps
module fast_ram_glue_chk (
    input logic clk_src,
    input logic rst_n,
    input logic io_ready,
    input logic phi2,
    input logic ram0_cs_n,
    input logic ram1_cs_n,
    input logic ram_oe_n,
    input logic ram_we_n,
    input logic rom_cs_n,
    input logic io_cs_n,
    input logic io_wait
);
    logic slow_n;
    logic ram_n;
    assign slow_n = rom_cs_n & io_cs_n;
    assign ram_n  = ram0_cs_n & ram1_cs_n;

    // values sampled at a rising edge are those of the low phase just ended
    AST_ONE_SELECT: assert property (@(posedge clk_src) disable iff (!rst_n)
        $countones({ram0_cs_n, ram1_cs_n, rom_cs_n, io_cs_n}) == 3); // R5
    AST_SLOW_STARTS_WAIT: assert property (@(posedge clk_src) disable iff (!rst_n)
        (!io_wait && !slow_n) |=> io_wait); // R7
    AST_STRETCH_HOLDS_PHI2: assert property (@(posedge clk_src) disable iff (!rst_n)
        io_wait |-> phi2); // R7
    AST_READY_RELEASES: assert property (@(posedge clk_src) disable iff (!rst_n)
        (io_wait && io_ready) |=> !io_wait); // R8
    AST_NOT_READY_KEEPS: assert property (@(posedge clk_src) disable iff (!rst_n)
        (io_wait && !io_ready) |=> io_wait); // R8
    AST_RAM_NO_WAIT: assert property (@(posedge clk_src) disable iff (!rst_n)
        (!io_wait && !ram_n) |=> !io_wait); // R6
    AST_IDLE_PHI2_LOW: assert property (@(posedge clk_src) disable iff (!rst_n)
        !io_wait |-> !phi2); // R6
    AST_WE_HIGH_LOW_PHASE: assert property (@(posedge clk_src) disable iff (!rst_n)
        ram_we_n); // R9
    AST_SLOW_BLOCKS_RAM: assert property (@(negedge clk_src) disable iff (!rst_n)
        !slow_n |-> (ram_oe_n && ram_we_n)); // R10
endmodule

bind fast_ram_glue fast_ram_glue_chk u_chk (
    .clk_src  (clk_src),
    .rst_n    (rst_n),
    .io_ready (io_ready),
    .phi2     (phi2),
    .ram0_cs_n(ram0_cs_n),
    .ram1_cs_n(ram1_cs_n),
    .ram_oe_n (ram_oe_n),
    .ram_we_n (ram_we_n),
    .rom_cs_n (rom_cs_n),
    .io_cs_n  (io_cs_n),
    .io_wait  (io_wait)
);

// File: tb/tb_fast_ram_glue.sv
`timescale 1ns/1ps
module tb_fast_ram_glue;

    typedef struct packed {
        logic [15:0] a;
        logic        rw;
        logic [3:0]  sel;   // {ram0, ram1, rom, io}
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{16'h0000, 1'b1, 4'b1000},
        '{16'h7FFF, 1'b0, 4'b1000},
        '{16'h8000, 1'b1, 4'b0100},
        '{16'hFDFF, 1'b0, 4'b0100},
        '{16'hFE00, 1'b1, 4'b0010},
        '{16'hFEFF, 1'b1, 4'b0010},
        '{16'hFF00, 1'b1, 4'b0001},
        '{16'hFFBF, 1'b0, 4'b0001},
        '{16'hFFC0, 1'b1, 4'b0010},
        '{16'hFFFF, 1'b0, 4'b0010},
        '{16'h4321, 1'b0, 4'b1000},
        '{16'hC000, 1'b1, 4'b0100},
        '{16'hFF80, 1'b1, 4'b0001},
        '{16'hFE55, 1'b0, 4'b0010}
    };

    logic        clk_src = 1'b0;
    logic        rst_n   = 1'b0;
    logic [15:0] addr    = 16'h0000;
    logic        rw      = 1'b1;
    logic        io_ready = 1'b1;
    logic phi2, ram0_cs_n, ram1_cs_n, ram_oe_n, ram_we_n, rom_cs_n, io_cs_n, io_wait;

    int total = 0;
    int bad   = 0;

    always #2 clk_src = ~clk_src;

    fast_ram_glue dut (
        .clk_src  (clk_src),
        .rst_n    (rst_n),
        .addr     (addr),
        .rw       (rw),
        .io_ready (io_ready),
        .phi2     (phi2),
        .ram0_cs_n(ram0_cs_n),
        .ram1_cs_n(ram1_cs_n),
        .ram_oe_n (ram_oe_n),
        .ram_we_n (ram_we_n),
        .rom_cs_n (rom_cs_n),
        .io_cs_n  (io_cs_n),
        .io_wait  (io_wait)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic r);
        @(negedge clk_src);
        #0.5;
        addr = a;
        rw   = r;
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R11: reset with a slow address on the bus
        addr = 16'hFE10;
        rw   = 1'b1;
        @(posedge clk_src); #1;
        check("R11 wait in reset", {31'd0, io_wait}, 32'd0);
        check("R11 phi2 high phase", {31'd0, phi2}, 32'd1);
        @(negedge clk_src); #1;
        check("R11 phi2 low phase", {31'd0, phi2}, 32'd0);
        addr = 16'h0000;
        @(negedge clk_src); #0.5;
        rst_n = 1'b1;

        // table: decode, strobes and minimum stretch (ready already high)
        for (int i = 0; i < NV; i++) begin
            logic slow;
            logic ram;
            slow = VEC[i].sel[1] | VEC[i].sel[0];
            ram  = VEC[i].sel[3] | VEC[i].sel[2];
            drive(VEC[i].a, VEC[i].rw);
            io_ready = 1'b1;
            #0.5;
            check("R1 ram0_cs_n", {31'd0, ram0_cs_n}, {31'd0, ~VEC[i].sel[3]});
            check("R2 ram1_cs_n", {31'd0, ram1_cs_n}, {31'd0, ~VEC[i].sel[2]});
            check("R3 rom_cs_n",  {31'd0, rom_cs_n},  {31'd0, ~VEC[i].sel[1]});
            check("R4 io_cs_n",   {31'd0, io_cs_n},   {31'd0, ~VEC[i].sel[0]});
            check("R10 oe_n", {31'd0, ram_oe_n}, {31'd0, ~(ram & VEC[i].rw)});
            check("R9 we_n low phase", {31'd0, ram_we_n}, 32'd1);
            @(posedge clk_src); #1;
            check("R9 we_n high phase", {31'd0, ram_we_n}, {31'd0, ~(ram & ~VEC[i].rw)});
            check("R7 wait after edge", {31'd0, io_wait}, {31'd0, slow});
            check("R6 phi2 high", {31'd0, phi2}, 32'd1);
            @(negedge clk_src); #1;
            check("R9 we_n after fall", {31'd0, ram_we_n}, 32'd1);
            if (slow) begin
                check("R7 phi2 held", {31'd0, phi2}, 32'd1);
                check("R10 oe_n slow", {31'd0, ram_oe_n}, 32'd1);
                @(posedge clk_src); #1;
                check("R8 released at first edge", {31'd0, io_wait}, 32'd0);
                check("R8 phi2 still high", {31'd0, phi2}, 32'd1);
                drive(16'h0000, 1'b1);
                #0.5;
                check("R8 phi2 falls", {31'd0, phi2}, 32'd0);
            end else begin
                check("R6 phi2 low phase", {31'd0, phi2}, 32'd0);
                check("R6 no wait", {31'd0, io_wait}, 32'd0);
            end
        end

        // R8: three not-ready edges then ready
        drive(16'hFF20, 1'b1);
        io_ready = 1'b0;
        @(posedge clk_src); #1;
        check("R7 wait set", {31'd0, io_wait}, 32'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk_src); #1;
            check("R8 phi2 held while not ready", {31'd0, phi2}, 32'd1);
            @(posedge clk_src); #1;
            check("R8 wait held while not ready", {31'd0, io_wait}, 32'd1);
        end
        @(negedge clk_src); #0.5;
        io_ready = 1'b1;
        #0.5;
        check("R8 phi2 held before ready edge", {31'd0, phi2}, 32'd1);
        @(posedge clk_src); #1;
        check("R8 wait drops", {31'd0, io_wait}, 32'd0);
        drive(16'h0000, 1'b1);
        #0.5;
        check("R8 phi2 low after release", {31'd0, phi2}, 32'd0);

        // R9: write to ROM never pulses RAM write enable
        drive(16'hFFF0, 1'b0);
        @(posedge clk_src); #1;
        check("R10 we_n on ROM write", {31'd0, ram_we_n}, 32'd1);
        @(posedge clk_src); #1;
        drive(16'h0000, 1'b1);

        // R11: reset in the middle of a stretch clears it at once
        drive(16'hFF10, 1'b1);
        io_ready = 1'b0;
        @(posedge clk_src); #1;
        check("R7 wait before reset", {31'd0, io_wait}, 32'd1);
        @(negedge clk_src); #0.5;
        rst_n = 1'b0;
        #0.5;
        check("R11 wait cleared", {31'd0, io_wait}, 32'd0);
        check("R11 phi2 follows clock", {31'd0, phi2}, 32'd0);
        addr = 16'h0000;
        io_ready = 1'b1;
        @(negedge clk_src); #0.5;
        rst_n = 1'b1;
        drive(16'h1234, 1'b1);
        @(posedge clk_src); #1;
        check("R6 after reset", {31'd0, io_wait}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule